// File: doc/BRIEF.md
# Serial ADC Frame and Power-State Controller

This block is the digital control core on the device side of a serial successive-approximation converter. A host frames each conversion with an active-low chip select and clocks it with a serial clock. The block counts serial-clock falling edges inside each frame, puts the track/hold into hold and starts a 16-bit output frame at the chip-select falling edge, releases the track/hold late in the frame and tri-states the data pin once the frame is complete. The frame carries four leading zeros and the conversion result MSB first; in the narrow (10-bit) mode, two trailing zeros pad the frame to the same length.

The same edge count also drives power management. The falling-edge count reached when chip select returns high decides between aborting, powering down, waking up, or ignoring the pulse as a glitch. Both entry to and exit from power-down need no extra pin. All inputs are sampled on a fast system clock, so the serial clock and chip select are treated as slow, already-synchronised levels. The analog converter loop is outside this block, and the result arrives as a parallel input.

Top module: `adcpm_ctrl`

## Requirements
- R1: After reset the data-enable, hold and abort outputs are 0, serial data is 0 and the analog power enable is 1 (powered state).
- R2: One cycle after chip select falls, hold and data-enable are 1 and serial data shows the first leading zero.
- R3: Result and mode are captured at the chip-select falling edge. In wide mode (narrow_i=0) the frame is 4 zeros then result[11:0] MSB first; in narrow mode (narrow_i=1) it is 4 zeros, result[9:0] MSB first, then 2 zeros. Frame bit 15 appears first, and after the k-th serial-clock falling edge frame bit 15-k is on serial data.
- R4: Data-enable goes to 0 on the 16th falling edge and stays 0 for the rest of the frame.
- R5: In the powered state, hold drops to 0 on the first serial-clock rising edge after the 13th falling edge, and stays 1 before that.
- R6: While chip select is high, data-enable and hold are 0.
- R7: Powered state, chip select rises after fewer than 2 falling edges: no abort, power stays on.
- R8: Powered state, chip select rises after 2 to 9 falling edges: a one-cycle abort pulse, and power enable drops to 0.
- R9: Chip select rises after 10 to 15 falling edges: a one-cycle abort pulse, and power stays on.
- R10: Power-down state: power enable returns to 1 after the chip-select falling edge. If chip select rises before the 10th falling edge, power enable drops to 0 again with no abort.
- R11: Power-down state: once a frame reaches its 10th falling edge, the block stays powered after chip select rises. A rise at 10 to 15 edges also pulses abort.
- R12: In a wake-up frame, hold drops to 0 on the first serial-clock edge after chip select falls.
- R13: The edge count saturates at 16. Falling edges beyond the 16th keep data-enable at 0, and a chip-select rise at or past 16 edges gives no abort and keeps power on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low chip select, synchronised |
| sclk_i | input | 1 | Serial clock level, synchronised |
| result_i | input | 12 | Parallel conversion result |
| narrow_i | input | 1 | 1 selects 10-bit frame layout |
| sdata_o | output | 1 | Serial data bit (0 when disabled) |
| sdata_oe_o | output | 1 | Output enable for the serial data pad |
| hold_o | output | 1 | 1 holds the track/hold, 0 tracks |
| pwr_en_o | output | 1 | Analog power enable |
| abort_o | output | 1 | One-cycle pulse when a conversion is cut short |

## Verification
The assertions assume four things about the inputs: chip select and the serial clock are synchronous to clk, every level is held for at least one sample, chip select never changes in the same sample as a serial-clock edge, and the first serial-clock edge of a frame comes at least two samples after chip select falls. The stimulus meets all four. It holds every serial-clock and chip-select level for four system cycles, moves chip select only while the serial clock is high and stable, and sweeps the falling-edge count at chip-select rise across each decision window, directed and random, from both power states.

// File: rtl/adcpm_pkg.sv
package adcpm_pkg;

    typedef enum logic [1:0] {
        PWR_ON     = 2'd0,
        PWR_OFF    = 2'd1,
        PWR_WAKING = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/adcpm_edges.sv
module adcpm_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    output logic cs_fall_o,
    output logic cs_rise_o,
    output logic sclk_fall_o,
    output logic sclk_rise_o
);

    typedef struct packed {
        logic cs_n;
        logic sclk;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cs_n = cs_n_i;
        st_d.sclk = sclk_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cs_n: 1'b1, sclk: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_fall_o   = st_q.cs_n & ~cs_n_i;
    assign cs_rise_o   = ~st_q.cs_n & cs_n_i;
    assign sclk_fall_o = st_q.sclk & ~sclk_i;
    assign sclk_rise_o = ~st_q.sclk & sclk_i;

endmodule

// File: rtl/adcpm_frame_seq.sv
module adcpm_frame_seq #(
    parameter int FRAME_LEN = 16,
    parameter int TRACK_AT  = 13,
    parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             cs_fall_i,
    input  logic             sclk_fall_i,
    input  logic             sclk_rise_i,
    input  logic             waking_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             oe_o,
    output logic             hold_o
);

    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_LASTB = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_TRACK = CNT_W'(TRACK_AT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             oe;
        logic             hold;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       frame_edge;

    assign frame_edge = ~cs_n_i & ~cs_fall_i;

    always_comb begin
        st_d = st_q;

        // falling-edge counter, saturating at a full frame
        if (cs_n_i || cs_fall_i) begin
            st_d.cnt = '0;
        end else if (sclk_fall_i && st_q.cnt != CNT_FULL) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        // output enable
        if (cs_n_i) begin
            st_d.oe = 1'b0;
        end else if (cs_fall_i) begin
            st_d.oe = 1'b1;
        end else if (sclk_fall_i && st_q.cnt == CNT_LASTB) begin
            st_d.oe = 1'b0;
        end

        // track/hold control
        if (cs_n_i) begin
            st_d.hold = 1'b0;
        end else if (cs_fall_i) begin
            st_d.hold = 1'b1;
        end else if (waking_i && st_q.cnt == '0 && (sclk_fall_i || sclk_rise_i)) begin
            st_d.hold = 1'b0;
        end else if (sclk_rise_i && st_q.cnt >= CNT_TRACK) begin
            st_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign oe_o   = st_q.oe;
    assign hold_o = st_q.hold;

    assert_hold_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall_i |=> (st_q.hold && st_q.oe));

    assert_oe_off_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_edge && sclk_fall_i && st_q.cnt == CNT_LASTB) |=> !st_q.oe);

    assert_track_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_edge && !waking_i && sclk_rise_i && st_q.cnt >= CNT_TRACK) |=> !st_q.hold);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> (!st_q.oe && !st_q.hold));

    assert_wake_track_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_edge && waking_i && st_q.cnt == '0 && (sclk_fall_i || sclk_rise_i)) |=> !st_q.hold);

    assert_cnt_saturate_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_edge && st_q.cnt == CNT_FULL) |=> (st_q.cnt == CNT_FULL && !st_q.oe));

endmodule

// File: rtl/adcpm_shifter.sv
module adcpm_shifter #(
    parameter int RES_W     = 12,
    parameter int NARROW_W  = 10,
    parameter int FRAME_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [RES_W-1:0] result_i,
    input  logic             narrow_i,
    output logic             msb_o
);

    localparam int LEAD  = FRAME_LEN - RES_W;
    localparam int TRAIL = RES_W - NARROW_W;

    typedef struct packed {
        logic [FRAME_LEN-1:0] sh;
    } sh_state_t;

    sh_state_t            st_d, st_q;
    logic [FRAME_LEN-1:0] wide_frame;
    logic [FRAME_LEN-1:0] narrow_frame;

    assign wide_frame = {{LEAD{1'b0}}, result_i};

    generate
        if (TRAIL > 0) begin : g_pad
            assign narrow_frame = {{LEAD{1'b0}}, result_i[NARROW_W-1:0], {TRAIL{1'b0}}};
        end else begin : g_same
            assign narrow_frame = wide_frame;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sh = narrow_i ? narrow_frame : wide_frame;
        end else if (shift_i) begin
            st_d.sh = {st_q.sh[FRAME_LEN-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msb_o = st_q.sh[FRAME_LEN-1];

    assert_lead_zeros_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.sh[FRAME_LEN-1 -: LEAD] == '0));

endmodule

// File: rtl/adcpm_pwr_fsm.sv
module adcpm_pwr_fsm
    import adcpm_pkg::*;
#(
    parameter int FRAME_LEN = 16,
    parameter int PD_LO     = 2,
    parameter int PD_HI     = 10,
    parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             cs_fall_i,
    input  logic             cs_rise_i,
    input  logic             sclk_fall_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             pwr_en_o,
    output logic             waking_o,
    output logic             abort_o
);

    localparam logic [CNT_W-1:0] C_LO   = CNT_W'(PD_LO);
    localparam logic [CNT_W-1:0] C_HI   = CNT_W'(PD_HI);
    localparam logic [CNT_W-1:0] C_WAKE = CNT_W'(PD_HI - 1);
    localparam logic [CNT_W-1:0] C_FULL = CNT_W'(FRAME_LEN);

    typedef struct packed {
        pwr_state_e state;
        logic       abort;
    } pwr_reg_t;

    pwr_reg_t st_d, st_q;
    logic     in_pd_window;
    logic     in_abort_window;

    assign in_pd_window    = (cnt_i >= C_LO) && (cnt_i < C_HI);
    assign in_abort_window = (cnt_i >= C_HI) && (cnt_i < C_FULL);

    always_comb begin
        st_d       = st_q;
        st_d.abort = 1'b0;
        unique case (st_q.state)
            PWR_ON: begin
                if (cs_rise_i) begin
                    if (in_pd_window) begin
                        st_d.state = PWR_OFF;
                        st_d.abort = 1'b1;
                    end else if (in_abort_window) begin
                        st_d.abort = 1'b1;
                    end
                end
            end
            PWR_OFF: begin
                if (cs_fall_i) begin
                    st_d.state = PWR_WAKING;
                end
            end
            PWR_WAKING: begin
                if (cs_rise_i) begin
                    st_d.state = PWR_OFF;
                end else if (!cs_n_i && sclk_fall_i && cnt_i == C_WAKE) begin
                    st_d.state = PWR_ON;
                end
            end
            default: st_d.state = PWR_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: PWR_ON, abort: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_en_o = (st_q.state != PWR_OFF);
    assign waking_o = (st_q.state == PWR_WAKING);
    assign abort_o  = st_q.abort;

    assert_glitch_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise_i && st_q.state == PWR_ON && cnt_i < C_LO) |=> (pwr_en_o && !abort_o));

    assert_enter_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise_i && st_q.state == PWR_ON && in_pd_window) |=> (!pwr_en_o && abort_o));

    assert_late_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise_i && st_q.state == PWR_ON && in_abort_window) |=> (pwr_en_o && abort_o));

    assert_wake_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise_i && st_q.state == PWR_WAKING) |=> (!pwr_en_o && !abort_o));

    assert_wake_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == PWR_WAKING && !cs_n_i && !cs_rise_i && sclk_fall_i && cnt_i == C_WAKE)
        |=> (st_q.state == PWR_ON));

    assert_abort_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

endmodule

// File: rtl/adcpm_ctrl.sv
module adcpm_ctrl #(
    parameter int RES_W     = 12,
    parameter int NARROW_W  = 10,
    parameter int LEAD_ZERO = 4,
    parameter int TRACK_AT  = 13,
    parameter int PD_LO     = 2,
    parameter int PD_HI     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             sclk_i,
    input  logic [RES_W-1:0] result_i,
    input  logic             narrow_i,
    output logic             sdata_o,
    output logic             sdata_oe_o,
    output logic             hold_o,
    output logic             pwr_en_o,
    output logic             abort_o
);

    localparam int FRAME_LEN = LEAD_ZERO + RES_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    logic             cs_fall, cs_rise, sclk_fall, sclk_rise;
    logic [CNT_W-1:0] cnt;
    logic             oe_q, waking, msb, shift_en;

    adcpm_edges u_edges (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_i      (cs_n_i),
        .sclk_i      (sclk_i),
        .cs_fall_o   (cs_fall),
        .cs_rise_o   (cs_rise),
        .sclk_fall_o (sclk_fall),
        .sclk_rise_o (sclk_rise)
    );

    adcpm_frame_seq #(
        .FRAME_LEN (FRAME_LEN),
        .TRACK_AT  (TRACK_AT),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_i      (cs_n_i),
        .cs_fall_i   (cs_fall),
        .sclk_fall_i (sclk_fall),
        .sclk_rise_i (sclk_rise),
        .waking_i    (waking),
        .cnt_o       (cnt),
        .oe_o        (oe_q),
        .hold_o      (hold_o)
    );

    assign shift_en = sclk_fall & ~cs_n_i & ~cs_fall;

    adcpm_shifter #(
        .RES_W     (RES_W),
        .NARROW_W  (NARROW_W),
        .FRAME_LEN (FRAME_LEN)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cs_fall),
        .shift_i  (shift_en),
        .result_i (result_i),
        .narrow_i (narrow_i),
        .msb_o    (msb)
    );

    adcpm_pwr_fsm #(
        .FRAME_LEN (FRAME_LEN),
        .PD_LO     (PD_LO),
        .PD_HI     (PD_HI),
        .CNT_W     (CNT_W)
    ) u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_i      (cs_n_i),
        .cs_fall_i   (cs_fall),
        .cs_rise_i   (cs_rise),
        .sclk_fall_i (sclk_fall),
        .cnt_i       (cnt),
        .pwr_en_o    (pwr_en_o),
        .waking_o    (waking),
        .abort_o     (abort_o)
    );

    // chip select high forces the pad off without waiting for a register
    assign sdata_oe_o = oe_q & ~cs_n_i;
    assign sdata_o    = sdata_oe_o & msb;

endmodule

// File: tb/adcpm_ctrl_tb_top.sv
`timescale 1ns/1ps
module adcpm_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] result = '0;
    logic        narrow = 1'b0;
    logic        sdata, sdata_oe, hold, pwr_en, abort_p;

    int  total = 0;
    int  bad = 0;
    logic pd_m = 1'b0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    adcpm_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n),
        .sclk_i     (sclk),
        .result_i   (result),
        .narrow_i   (narrow),
        .sdata_o    (sdata),
        .sdata_oe_o (sdata_oe),
        .hold_o     (hold),
        .pwr_en_o   (pwr_en),
        .abort_o    (abort_p)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_frame(input logic [11:0] r, input logic m10);
        return m10 ? {4'b0000, r[9:0], 2'b00} : {4'b0000, r};
    endfunction

    task automatic run_frame(input logic [11:0] res, input logic m10, input int nf,
                             input logic mutate);
        logic [15:0] fr;
        logic        start_pd, exp_ab, exp_pd;
        int          exp_hold;
        string       tag;
        start_pd = pd_m;
        fr = exp_frame(res, m10);
        result = res;
        narrow = m10;
        idle(2);
        cs_n = 1'b0;
        idle(4);
        if (mutate) begin
            result = ~res;   // R3: capture at chip-select fall
            narrow = ~m10;
        end
        chk("R2 oe after cs fall", sdata_oe, 1);
        chk("R2 hold after cs fall", hold, 1);
        chk("R2 first lead zero", sdata, 0);
        if (start_pd) chk("R10 power up on cs fall", pwr_en, 1);
        for (int k = 1; k <= nf; k++) begin
            sclk = 1'b0;
            idle(4);
            if (k < 16) begin
                chk($sformatf("R3 data bit after fall %0d", k), sdata, fr[15-k]);
                chk("R4 oe within frame", sdata_oe, 1);
            end else begin
                chk("R4 oe off at end", sdata_oe, 0);
                if (k > 16) chk("R13 oe off past saturation", sdata_oe, 0);
            end
            if (k == 1) chk(start_pd ? "R12 wake track on first edge" : "R5 hold early",
                            hold, start_pd ? 0 : 1);
            sclk = 1'b1;
            idle(4);
            exp_hold = start_pd ? 0 : ((k >= 13) ? 0 : 1);
            chk(start_pd ? "R12 wake hold" : "R5 hold release", hold, exp_hold);
        end
        if (!start_pd) begin
            if (nf < 2)       begin exp_ab = 0; exp_pd = 0; tag = "R7"; end
            else if (nf < 10) begin exp_ab = 1; exp_pd = 1; tag = "R8"; end
            else if (nf < 16) begin exp_ab = 1; exp_pd = 0; tag = "R9"; end
            else              begin exp_ab = 0; exp_pd = 0; tag = "R13"; end
        end else begin
            if (nf < 10)      begin exp_ab = 0; exp_pd = 1; tag = "R10"; end
            else if (nf < 16) begin exp_ab = 1; exp_pd = 0; tag = "R11"; end
            else              begin exp_ab = 0; exp_pd = 0; tag = "R11"; end
        end
        cs_n = 1'b1;
        @(negedge clk);
        chk({tag, " abort at cs rise"}, abort_p, exp_ab);
        chk({tag, " power after cs rise"}, pwr_en, !exp_pd);
        @(negedge clk);
        chk("R9 abort single cycle", abort_p, 0);
        chk("R6 oe off while idle", sdata_oe, 0);
        chk("R6 hold off while idle", hold, 0);
        pd_m = exp_pd;
        idle(2);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R1 oe reset", sdata_oe, 0);
        chk("R1 hold reset", hold, 0);
        chk("R1 abort reset", abort_p, 0);
        chk("R1 sdata reset", sdata, 0);
        chk("R1 power reset", pwr_en, 1);

        run_frame(12'hA5C, 1'b0, 16, 1'b1);   // full wide frame
        run_frame(12'h3FF, 1'b1, 16, 1'b0);   // full narrow frame
        run_frame(12'h2B6, 1'b1, 16, 1'b1);
        run_frame(12'hFFF, 1'b0, 0, 1'b0);    // R7 no edges
        run_frame(12'h001, 1'b0, 1, 1'b0);    // R7 one edge
        run_frame(12'h800, 1'b0, 2, 1'b0);    // R8 low boundary
        run_frame(12'h123, 1'b0, 3, 1'b0);    // R10 wake fails
        run_frame(12'h456, 1'b0, 9, 1'b0);    // R10 wake fails at 9
        run_frame(12'h789, 1'b0, 10, 1'b0);   // R11 wake at 10
        run_frame(12'hABC, 1'b0, 9, 1'b0);    // R8 high boundary
        run_frame(12'hDEF, 1'b1, 16, 1'b0);   // R11 full dummy frame
        run_frame(12'h5A5, 1'b0, 15, 1'b0);   // R9 high boundary
        run_frame(12'h0F0, 1'b0, 20, 1'b0);   // R13 saturation

        for (int i = 0; i < 40; i++) begin
            run_frame(12'($urandom), 1'($urandom_range(0, 1)),
                      int'($urandom_range(0, 20)), 1'($urandom_range(0, 1)));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule